// File: doc/BRIEF.md
# Pipelined Burst SRAM with Zero Bus Turnaround

A synthesizable model of a synchronous, fully pipelined static RAM that holds 36-bit words split into four 9-bit byte lanes. Reads and writes travel down the same two-stage pipeline. Write data is taken from the input bus at the same pipeline depth where read data is placed on the output bus. A read may therefore follow a write, or a write follow a read, on the very next clock with no idle cycle between them.

Each enabled rising edge either loads a new command or advances the current burst. Loading a command uses the address, the three chip enables, the read/write input and the byte enables. Advancing reuses the command type and the upper address bits, and steps the two low address bits through a four-beat sequence. The sequence is linear or interleaved, as a static mode pin selects. A clock-enable input freezes the whole pipeline. A snooze input silences the outputs and shuts out new commands while it is high and for two edges after it falls.

Top module: `pipe_burst_sram`

## Requirements
- R1: After reset the block is deselected, the burst count is zero and `q_oe_o` stays low until a read reaches the output.
- R2: Read data for a command sampled at enabled edge k is registered at enabled edge k+2 and is driven from then until the next enabled edge.
- R3: A write updates byte lane i (bits 9i+8..9i) only where `bw_ni[i]` is 0 in that beat. A beat whose `bw_ni` is all ones (4'b1111) leaves the word unchanged.
- R4: Write data for a beat sampled at enabled edge k is taken from `d_i` at enabled edge k+2. A read of that word in any later beat, including the very next one, returns the merged data.
- R5: A load (`load_ni`=0) with `ce1_ni`=1, `ce2_i`=0 or `ce3_ni`=1 is a deselect. It neither drives the bus nor writes, and advance beats that follow it stay deselected.
- R6: An advance beat (`load_ni`=1) repeats the last loaded command type and keeps the upper address bits. It changes only address bits 1:0, and the burst count wraps modulo 4.
- R7: With `lin_ni`=1, beat n of a burst uses low address bits (start XOR n).
- R8: With `lin_ni`=0, beat n of a burst uses low address bits ((start + n) mod 4).
- R9: Read data is driven only while `oe_ni` is 0. A read whose output phase sees `oe_ni`=1 drives nothing and leaves memory unchanged.
- R10: With `cke_ni`=1 the edge is ignored: no pipeline register, burst count, output register or memory word changes.
- R11: While `zz_i` is 1 the outputs are not driven. Any edge sampled with `zz_i`=1, and the next two edges after it falls, load a deselect in place of the presented command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_ni | input | 1 | Clock enable, active low; high stalls everything |
| ce1_ni | input | 1 | Chip enable 1, active low |
| ce2_i | input | 1 | Chip enable 2, active high |
| ce3_ni | input | 1 | Chip enable 3, active low |
| load_ni | input | 1 | Low: load a new command; high: advance the burst |
| we_ni | input | 1 | Low: write; high: read (at load) |
| bw_ni | input | 4 | Per-lane write enables, active low, sampled every beat |
| addr_i | input | ADDR_W | Word address |
| d_i | input | 36 | Write data |
| lin_ni | input | 1 | Static burst order: low linear, high interleaved |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| zz_i | input | 1 | Snooze request, asynchronous |
| q_o | output | 36 | Read data, zero when not driven |
| q_oe_o | output | 1 | High when `q_o` is driven |

## Verification
The stimulus is a full-memory fill with linear bursts, followed by reads that start at every offset, so that an error in the linear or interleaved order shows up as a data mismatch. Write-read-write-read sequences on one address, with no gaps, separate correct write timing from data taken one edge early or late. Partial and all-high byte masks show which lanes a write touches. Deselects for each of the three enables, dummy reads, stalls placed inside write and read pipelines, and snooze pulses during traffic test the paths that must leave state alone. A random mixed phase then checks the output pins on every clock against a behavioural array-and-pipeline reference.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam int BURST_W = 2;
  typedef enum logic [1:0] {OP_IDLE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2} op_e;
endpackage

// File: rtl/pbs_burst_gen.sv
module pbs_burst_gen #(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] start_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             lin_i,
  output logic [CNT_W-1:0] offs_o
);
  always_comb begin
    if (lin_i) offs_o = start_i + cnt_i;
    else       offs_o = start_i ^ cnt_i;
  end
endmodule

// File: rtl/pbs_cmd_ctrl.sv
module pbs_cmd_ctrl
  import pbs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               zz_i,
  input  logic               ce1_ni,
  input  logic               ce2_i,
  input  logic               ce3_ni,
  input  logic               load_ni,
  input  logic               we_ni,
  input  logic               lin_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  output op_e                op_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               blocked_o,
  output logic [BURST_W-1:0] cnt_o
);
  logic [1:0]         zz_hist_q;
  op_e                op_q;
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q, cnt_nxt, offs;
  logic               reload, sel;

  assign blocked_o = zz_i | (|zz_hist_q);
  assign reload    = blocked_o | ~load_ni;
  assign sel       = ~ce1_ni & ce2_i & ~ce3_ni;
  assign cnt_nxt   = cnt_q + 1'b1;
  assign cnt_o     = cnt_q;

  pbs_burst_gen #(.CNT_W(BURST_W)) u_gen (
    .start_i (base_q[BURST_W-1:0]),
    .cnt_i   (cnt_nxt),
    .lin_i   (~lin_ni),
    .offs_o  (offs)
  );

  always_comb begin
    if (blocked_o) begin
      op_o   = OP_IDLE;
      addr_o = addr_i;
    end else if (!load_ni) begin
      op_o   = !sel ? OP_IDLE : (we_ni ? OP_RD : OP_WR);
      addr_o = addr_i;
    end else begin
      op_o   = op_q;
      addr_o = {base_q[ADDR_W-1:BURST_W], offs};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zz_hist_q <= '0;
      op_q      <= OP_IDLE;
      base_q    <= '0;
      cnt_q     <= '0;
    end else begin
      zz_hist_q <= {zz_hist_q[0], zz_i};
      if (en_i) begin
        if (reload) begin
          op_q   <= op_o;
          base_q <= addr_i;
          cnt_q  <= '0;
        end else begin
          cnt_q  <= cnt_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/pbs_mem.sv
module pbs_mem #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] arr [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && be_i[g]) arr[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end
    assign rdata_o[g*LANE_W +: LANE_W] = arr[raddr_i];
  end
endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
  import pbs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_ni,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              ce3_ni,
  input  logic              load_ni,
  input  logic              we_ni,
  input  logic [LANES-1:0]  bw_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] d_i,
  input  logic              lin_ni,
  input  logic              oe_ni,
  input  logic              zz_i,
  output logic [DATA_W-1:0] q_o,
  output logic              q_oe_o
);
  logic               en, blocked;
  op_e                cyc_op, a_op, b_op;
  logic [ADDR_W-1:0]  cyc_addr, a_addr, b_addr;
  logic [LANES-1:0]   a_be, b_be;
  logic [BURST_W-1:0] burst_cnt;
  logic [DATA_W-1:0]  rdata, q_q;
  logic               q_vld;

  assign en = ~cke_ni;

  pbs_cmd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i, .rst_ni, .en_i(en), .zz_i, .ce1_ni, .ce2_i, .ce3_ni,
    .load_ni, .we_ni, .lin_ni, .addr_i,
    .op_o(cyc_op), .addr_o(cyc_addr), .blocked_o(blocked), .cnt_o(burst_cnt)
  );

  pbs_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk_i, .we_i(en && b_op == OP_WR), .be_i(b_be), .waddr_i(b_addr),
    .wdata_i(d_i), .raddr_i(b_addr), .rdata_o(rdata)
  );

  // two stages: command -> address stage -> data phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_op <= OP_IDLE; a_addr <= '0; a_be <= '0;
      b_op <= OP_IDLE; b_addr <= '0; b_be <= '0;
      q_q  <= '0;      q_vld  <= 1'b0;
    end else if (en) begin
      a_op   <= cyc_op;
      a_addr <= cyc_addr;
      a_be   <= ~bw_ni;
      b_op   <= a_op;
      b_addr <= a_addr;
      b_be   <= a_be;
      q_vld  <= (b_op == OP_RD);
      if (b_op == OP_RD) q_q <= rdata;
    end
  end

  assign q_oe_o = q_vld & ~oe_ni & ~zz_i;
  assign q_o    = q_oe_o ? q_q : '0;
endmodule

// File: rtl/pbs_chk.sv
module pbs_chk
  import pbs_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cke_ni,
  input logic               load_ni,
  input logic               ce1_ni,
  input logic               ce2_i,
  input logic               ce3_ni,
  input logic               blocked,
  input op_e                a_op,
  input op_e                b_op,
  input logic               q_vld,
  input logic [DATA_W-1:0]  q_q,
  input logic [BURST_W-1:0] burst_cnt
);
  AST_RD_TO_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && b_op == OP_RD) |=> q_vld); // R2
  AST_DESEL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !blocked && !load_ni && (ce1_ni || !ce2_i || ce3_ni)) |=> a_op == OP_IDLE); // R5
  AST_BURST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !blocked && load_ni) |=> burst_cnt == BURST_W'($past(burst_cnt) + 1'b1)); // R6
  AST_STALL_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_ni |=> ($stable(q_q) && $stable(q_vld) && $stable(burst_cnt) && $stable(a_op) && $stable(b_op))); // R10
  AST_SNOOZE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && blocked) |=> a_op == OP_IDLE); // R11
endmodule

bind pipe_burst_sram pbs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .cke_ni, .load_ni, .ce1_ni, .ce2_i, .ce3_ni,
  .blocked, .a_op, .b_op, .q_vld, .q_q, .burst_cnt
);

// File: tb/tb_pipe_burst_sram.sv
module tb_pipe_burst_sram;
  localparam int AW = 6, DW = 36, DEPTH = 64;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_ni, cke_ni, ce1_ni, ce2_i, ce3_ni, load_ni, we_ni, lin_ni, oe_ni, zz_i;
  logic [3:0]    bw_ni;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] d_i, q_o;
  logic          q_oe_o;

  pipe_burst_sram dut (
    .clk_i(clk), .rst_ni, .cke_ni, .ce1_ni, .ce2_i, .ce3_ni, .load_ni, .we_ni,
    .bw_ni, .addr_i, .d_i, .lin_ni, .oe_ni, .zz_i, .q_o, .q_oe_o
  );

  int    n_chk = 0, n_fail = 0;
  string req = "R1";

  // reference model
  logic [DW-1:0] ref_mem [DEPTH];
  int            p_op [2], p_addr [2];
  logic [3:0]    p_be [2];
  int            m_op = 0, m_base = 0, m_cnt = 0;
  logic [1:0]    m_zz = 2'b00;
  logic          m_qv = 1'b0;
  logic [DW-1:0] m_q = '0;

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", r, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic exp_oe;
    exp_oe = m_qv & ~oe_ni & ~zz_i;
    chk(q_oe_o == exp_oe, req, 64'(q_oe_o), 64'(exp_oe));
    if (exp_oe) chk(q_o == m_q, req, 64'(q_o), 64'(m_q));
  endtask

  function automatic int boff(int s, int c);
    return lin_ni ? (s ^ c) : ((s + c) % 4);
  endfunction

  task automatic model_edge();
    bit blk;
    int cop, cad;
    blk = zz_i || (m_zz != 2'b00);
    if (!cke_ni) begin
      if (p_op[0] == 2)
        for (int l = 0; l < 4; l++)
          if (p_be[0][l]) ref_mem[p_addr[0]][l*9 +: 9] = d_i[l*9 +: 9];
      m_qv = (p_op[0] == 1);
      if (m_qv) m_q = ref_mem[p_addr[0]];
      if (blk || !load_ni) begin
        if (blk) cop = 0;
        else if (ce1_ni || !ce2_i || ce3_ni) cop = 0;
        else cop = we_ni ? 1 : 2;
        m_op = cop; m_base = int'(addr_i); m_cnt = 0; cad = int'(addr_i);
      end else begin
        m_cnt = (m_cnt + 1) % 4;
        cop = m_op;
        cad = (m_base & ~3) | boff(m_base % 4, m_cnt);
      end
      p_op[0] = p_op[1]; p_addr[0] = p_addr[1]; p_be[0] = p_be[1];
      p_op[1] = cop; p_addr[1] = cad; p_be[1] = ~bw_ni;
    end
    m_zz = {m_zz[0], zz_i};
  endtask

  task automatic cyc();
    logic [63:0] r;
    r = {$urandom(), $urandom()};
    d_i = r[DW-1:0];
    #1;
    compare();
    model_edge();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmd(input logic ld_n, input logic e1n, input logic e2, input logic e3n,
                     input logic w_n, input logic [3:0] bw, input int a);
    load_ni = ld_n; ce1_ni = e1n; ce2_i = e2; ce3_ni = e3n;
    we_ni = w_n; bw_ni = bw; addr_i = AW'(a);
    cyc();
  endtask

  task automatic wr(input int a, input logic [3:0] bw); cmd(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, bw, a); endtask
  task automatic rd(input int a); cmd(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, a); endtask
  task automatic adv(input logic [3:0] bw);
    cmd(1'b1, 1'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()), bw, int'($urandom() % DEPTH));
  endtask
  task automatic dsel(); cmd(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 0); endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin p_op[i] = 0; p_addr[i] = 0; p_be[i] = 4'h0; end
    rst_ni = 1'b0; cke_ni = 1'b0; ce1_ni = 1'b1; ce2_i = 1'b1; ce3_ni = 1'b0;
    load_ni = 1'b0; we_ni = 1'b1; bw_ni = 4'hF; addr_i = '0; d_i = '0;
    lin_ni = 1'b0; oe_ni = 1'b0; zz_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    req = "R1";
    #1 chk(q_oe_o == 1'b0, "R1", 64'(q_oe_o), 64'd0);
    for (int i = 0; i < 3; i++) adv(4'h0);

    // fill whole memory with linear bursts
    req = "R8";
    for (int b = 0; b < DEPTH / 4; b++) begin
      wr(4 * b, 4'h0);
      for (int k = 0; k < 3; k++) adv(4'h0);
    end
    dsel(); dsel();

    // linear read bursts from every start offset
    req = "R2";
    for (int s = 0; s < 4; s++) begin
      rd(20 + s);
      for (int k = 0; k < 3; k++) adv(4'hF);
    end
    dsel(); dsel(); dsel();

    // interleaved bursts, write and read from several offsets
    req = "R7";
    lin_ni = 1'b1;
    dsel();
    for (int s = 0; s < 4; s++) begin
      wr(32 + s, 4'h0);
      for (int k = 0; k < 3; k++) adv(4'h0);
      rd(32 + ((s + 1) % 4));
      for (int k = 0; k < 3; k++) adv(4'hF);
    end
    dsel(); dsel(); dsel();
    lin_ni = 1'b0;
    dsel();

    // lane masks and write abort, including inside a burst
    req = "R3";
    wr(8, 4'b1010); wr(9, 4'b1111); wr(10, 4'b0110);
    wr(12, 4'b1110); adv(4'b1111); adv(4'b0111); adv(4'b1101);
    rd(8); rd(9); rd(10); rd(12); adv(4'hF); adv(4'hF); adv(4'hF);
    dsel(); dsel(); dsel();

    // zero-gap write/read alternation on one word
    req = "R4";
    for (int i = 0; i < 6; i++) begin wr(5, 4'($urandom())); rd(5); end
    wr(6, 4'h0); rd(6); rd(5); wr(5, 4'h0); wr(6, 4'h3); rd(6); rd(5);
    dsel(); dsel(); dsel();

    // deselect via each enable, writes with deselect must not land
    req = "R5";
    cmd(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 40); adv(4'h0); adv(4'h0);
    cmd(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 44); adv(4'h0);
    cmd(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 44); adv(4'hF); adv(4'hF);
    rd(40); adv(4'hF); rd(44); adv(4'hF);
    dsel(); dsel(); dsel();

    // advance keeps type and upper bits
    req = "R6";
    rd(50); for (int k = 0; k < 7; k++) adv(4'hF);
    wr(54, 4'h0); for (int k = 0; k < 5; k++) adv(4'h0);
    rd(54); for (int k = 0; k < 3; k++) adv(4'hF);
    dsel(); dsel(); dsel();

    // dummy read with output disabled
    req = "R9";
    rd(30); adv(4'hF); oe_ni = 1'b1; adv(4'hF); adv(4'hF); oe_ni = 1'b0; adv(4'hF);
    dsel(); dsel(); rd(30); dsel(); dsel(); dsel();

    // stalls in the middle of read and write pipelines
    req = "R10";
    rd(16); cke_ni = 1'b1; adv(4'h0); adv(4'h0); cke_ni = 1'b0; adv(4'hF); adv(4'hF);
    cke_ni = 1'b1; dsel(); cke_ni = 1'b0; dsel(); dsel();
    wr(17, 4'h0); adv(4'h0); cke_ni = 1'b1; wr(18, 4'h0); rd(17); cke_ni = 1'b0; dsel(); dsel();
    rd(17); rd(18); dsel(); dsel(); dsel();

    // snooze during traffic and recovery window
    req = "R11";
    rd(24); adv(4'hF); zz_i = 1'b1; adv(4'hF); rd(25); wr(26, 4'h0); zz_i = 1'b0;
    wr(27, 4'h0); rd(28); rd(29); adv(4'hF); dsel(); dsel();
    rd(26); rd(27); dsel(); dsel(); dsel();

    // random mixed traffic
    req = "R4";
    for (int i = 0; i < 600; i++) begin
      cke_ni = ($urandom() % 6 == 0);
      oe_ni  = ($urandom() % 5 == 0);
      zz_i   = ($urandom() % 40 == 0);
      cmd(1'($urandom() % 3 == 0), 1'($urandom() % 8 == 0), 1'($urandom() % 8 != 0),
          1'($urandom() % 8 == 0), 1'($urandom()), 4'($urandom()), int'($urandom() % DEPTH));
    end
    cke_ni = 1'b0; oe_ni = 1'b0; zz_i = 1'b0;
    for (int i = 0; i < 5; i++) dsel();

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule